// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Rotate

This combinational unit sits in front of a processor's arithmetic and logic stage. It reshapes the second operand before that stage uses it. A 3-bit type code picks the operation: logical left shift, logical right shift, arithmetic right shift or rotate right. A 5-bit amount says how many positions to move. Every operation also returns a carry-out bit, which is the last bit that left the operand, so the flag logic downstream can record it.

A rotate right with an amount of zero has its own meaning. It is a one-position rotate through the incoming carry flag, so the flag acts as a 33rd bit of the word. For the other operation types, an amount of zero leaves the operand unchanged and passes the incoming carry straight through. Type codes that no operation uses behave the same way. The result follows the inputs within the same cycle, with no register on the path.

Top module: `barrel_shifter`

## Requirements
- R1: With type code 0 (logical left) and amount n from 1 to 31, the result is the operand shifted toward the MSB by n with zeros filling the low bits, and carry-out is operand bit 32-n.
- R2: With type code 1 (logical right) and n from 1 to 31, the result is the operand shifted toward the LSB by n with zeros filling the high bits, and carry-out is operand bit n-1.
- R3: With type code 2 (arithmetic right) and n from 1 to 31, the vacated high bits take copies of operand bit 31, and carry-out is operand bit n-1.
- R4: With type code 3 (rotate right) and n from 1 to 31, bits leaving the LSB end come back in at the MSB end, and carry-out is operand bit n-1 (equal to result bit 31).
- R5: With type code 3 and amount 0, the result is {carry-in, operand[31:1]} and carry-out is operand bit 0.
- R6: With type codes 0, 1 or 2 and amount 0, the result equals the operand and carry-out equals carry-in.
- R7: With type codes 4 to 7, the amount has no effect: the result equals the operand and carry-out equals carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opIn | input | 32 | Operand to be shifted |
| shiftType | input | 3 | Operation code (0 left, 1 right, 2 arithmetic right, 3 rotate right) |
| shiftAmt | input | 5 | Number of positions, 0 to 31 |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | 32 | Shifted operand |
| carryOut | output | 1 | Last bit shifted out, or the carry passed through |

## Verification
Two behaviours can meet on the same input: the rotate code with an amount of zero must switch from the plain rotate to the 33-bit carry rotate, and the zero-amount bypass shares the carry output with that carry rotate. The bench provokes both by sweeping every type code across every amount, amount 0 included, with both carry-in values. It judges the result and carry-out against an independent model, and adds directed rows for the extreme amounts 1 and 31 and for sign-bit patterns.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  localparam int OP_W  = 32;
  localparam int AMT_W = $clog2(OP_W);

  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3
  } shiftType_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic reverse;   // mirror operand so a right network performs a left shift
    logic fillSign;  // fill vacated high bits with the sign bit
    logic rotate;    // wrap bits around the word
    logic carryRot;  // one-position rotate through the carry flag
    logic bypass;    // pass operand and carry unchanged
  } shiftStrobe_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
(
  input  logic [2:0]   shiftType,
  input  logic         amtZero,
  output shiftStrobe_t strb
);

  always_comb begin
    strb = '0;
    case (shiftType)
      SH_LSL: begin
        strb.reverse = 1'b1;
        strb.bypass  = amtZero;
      end
      SH_LSR: begin
        strb.bypass  = amtZero;
      end
      SH_ASR: begin
        strb.fillSign = 1'b1;
        strb.bypass   = amtZero;
      end
      SH_ROR: begin
        strb.carryRot = amtZero;
        strb.rotate   = !amtZero;
      end
      default: begin
        strb.bypass = 1'b1;
      end
    endcase
  end

  // R5 R7: at most one of the final-stage selections is active
  always_comb begin
    // R5
    ctrl_excl_chk: assert ($onehot0({strb.carryRot, strb.bypass, strb.rotate}))
      else $error("ctrl_excl_chk: conflicting strobes");
  end

endmodule

// File: rtl/shift_dp.sv
module shift_dp
  import shifter_pkg::*;
#(
  parameter int W  = OP_W,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] amount,
  input  logic          carryIn,
  input  shiftStrobe_t  strb,
  output logic [W-1:0]  result,
  output logic          carryOut
);

  localparam int EXT_W = W + 1;

  logic [W-1:0] revOp;
  logic [W-1:0] preOp;
  logic         fillBit;
  logic [EXT_W-1:0] stage [AW+1];
  logic [W-1:0] netOut;
  logic [W-1:0] revNet;
  logic [W-1:0] postOp;
  logic         netCarry;

  // Mirror the operand so one right-moving network serves both directions
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign revOp[i]  = operand[W-1-i];
    assign revNet[i] = netOut[W-1-i];
  end

  assign preOp    = strb.reverse ? revOp : operand;
  assign fillBit  = strb.fillSign & operand[W-1];
  // A guard bit below the word catches the last bit shifted out
  assign stage[0] = {preOp, 1'b0};

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0]     upper;
    logic [W-1:0]     wrapped;
    logic [EXT_W-1:0] shifted;
    assign upper   = stage[k][EXT_W-1:1];
    assign wrapped = {upper[S-1:0], upper[W-1:S]};
    assign shifted = {{S{fillBit}}, stage[k][EXT_W-1:S]};
    assign stage[k+1] = !amount[k] ? stage[k]
                      : (strb.rotate ? {wrapped, 1'b0} : shifted);
  end

  assign netOut   = stage[AW][EXT_W-1:1];
  assign netCarry = strb.rotate ? netOut[W-1] : stage[AW][0];
  assign postOp   = strb.reverse ? revNet : netOut;

  always_comb begin
    if (strb.bypass) begin
      result   = operand;
      carryOut = carryIn;
    end else if (strb.carryRot) begin
      result   = {carryIn, operand[W-1:1]};
      carryOut = operand[0];
    end else begin
      result   = postOp;
      carryOut = netCarry;
    end
  end

  always_comb begin
    // R4
    rot_popcount_chk: assert (!strb.rotate || ($countones(result) == $countones(operand)))
      else $error("rot_popcount_chk: rotate changed bit count");
  end

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import shifter_pkg::*;
(
  input  logic [31:0] opIn,
  input  logic [2:0]  shiftType,
  input  logic [4:0]  shiftAmt,
  input  logic        carryIn,
  output logic [31:0] resultOut,
  output logic        carryOut
);

  shiftStrobe_t strb;

  shift_ctrl u_ctrl (
    .shiftType (shiftType),
    .amtZero   (shiftAmt == '0),
    .strb      (strb)
  );

  shift_dp #(.W(OP_W), .AW(AMT_W)) u_dp (
    .operand  (opIn),
    .amount   (shiftAmt),
    .carryIn  (carryIn),
    .strb     (strb),
    .result   (resultOut),
    .carryOut (carryOut)
  );

  always_comb begin
    // R1
    lsl_zero_fill_chk: assert (!(shiftType == 3'd0 && shiftAmt != 0) || resultOut[0] == 1'b0)
      else $error("lsl_zero_fill_chk");
    // R2
    lsr_zero_fill_chk: assert (!(shiftType == 3'd1 && shiftAmt != 0) || resultOut[31] == 1'b0)
      else $error("lsr_zero_fill_chk");
    // R3
    asr_sign_keep_chk: assert (shiftType != 3'd2 || resultOut[31] == opIn[31])
      else $error("asr_sign_keep_chk");
    // R5
    carry_rot_chk: assert (!(shiftType == 3'd3 && shiftAmt == 0) ||
                           (carryOut == opIn[0] && resultOut[31] == carryIn))
      else $error("carry_rot_chk");
    // R6 R7
    bypass_chk: assert (!((shiftType != 3'd3 && shiftAmt == 0) || shiftType[2]) ||
                        (resultOut == opIn && carryOut == carryIn))
      else $error("bypass_chk");
  end

endmodule

// File: tb/tb_barrel_shifter.sv
module tb_barrel_shifter;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [31:0] opIn;
  logic [2:0]  shiftType;
  logic [4:0]  shiftAmt;
  logic        carryIn;
  logic [31:0] resultOut;
  logic        carryOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  barrel_shifter dut (
    .opIn(opIn), .shiftType(shiftType), .shiftAmt(shiftAmt),
    .carryIn(carryIn), .resultOut(resultOut), .carryOut(carryOut)
  );

  typedef struct packed {
    logic [2:0]  t;
    logic [4:0]  n;
    logic        ci;
    logic [31:0] op;
    logic [31:0] res;
    logic        co;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 5'd0,  1'b0, 32'h00000000, 32'h00000000, 1'b0}, // R6 idle zero
    '{3'd2, 5'd8,  1'b0, 32'h80000000, 32'hFF800000, 1'b0}, // R3
    '{3'd2, 5'd31, 1'b1, 32'h80000000, 32'hFFFFFFFF, 1'b0}, // R3
    '{3'd3, 5'd8,  1'b0, 32'h12345678, 32'h78123456, 1'b0}, // R4
    '{3'd3, 5'd1,  1'b0, 32'h00000001, 32'h80000000, 1'b1}, // R4
    '{3'd0, 5'd1,  1'b0, 32'h80000001, 32'h00000002, 1'b1}, // R1
    '{3'd0, 5'd31, 1'b0, 32'h00000003, 32'h80000000, 1'b1}, // R1
    '{3'd1, 5'd4,  1'b0, 32'h0000000F, 32'h00000000, 1'b1}, // R2
    '{3'd1, 5'd31, 1'b1, 32'h80000000, 32'h00000001, 1'b0}, // R2
    '{3'd3, 5'd0,  1'b1, 32'h00000001, 32'h80000000, 1'b1}, // R5
    '{3'd3, 5'd0,  1'b0, 32'hFFFFFFFE, 32'h7FFFFFFF, 1'b0}, // R5
    '{3'd5, 5'd7,  1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1}  // R7
  };

  function automatic string reqName(input logic [2:0] t, input logic [4:0] n);
    if (t[2])             return "R7";
    if (t == 3'd3)        return (n == 0) ? "R5" : "R4";
    if (n == 0)           return "R6";
    if (t == 3'd0)        return "R1";
    if (t == 3'd1)        return "R2";
    return "R3";
  endfunction

  // Independent reference: {carry, result}
  function automatic logic [32:0] refModel(input logic [2:0] t, input logic [31:0] op,
                                           input int n, input logic ci);
    logic [63:0] wide;
    if (t[2] || (n == 0 && t != 3'd3)) return {ci, op};
    case (t)
      3'd0: return {op[32-n], op << n};
      3'd1: return {op[n-1], op >> n};
      3'd2: begin
        wide = {{32{op[31]}}, op} >> n;
        return {op[n-1], wide[31:0]};
      end
      default: begin
        if (n == 0) return {op[0], ci, op[31:1]};
        wide = {op, op} >> n;
        return {op[n-1], wide[31:0]};
      end
    endcase
  endfunction

  task automatic apply(input logic [2:0] t, input logic [4:0] n, input logic ci,
                       input logic [31:0] op, input logic [31:0] expRes,
                       input logic expCo, input string tag);
    @(negedge clk);
    shiftType = t; shiftAmt = n; carryIn = ci; opIn = op;
    #5;
    checks++;
    if (resultOut !== expRes || carryOut !== expCo) begin
      fails++;
      $display("FAIL %s type=%0d amt=%0d ci=%0b op=%h: got %h/%0b expected %h/%0b",
               tag, t, n, ci, op, resultOut, carryOut, expRes, expCo);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [32:0] exp;
    logic [31:0] ops [4];
    opIn = '0; shiftType = '0; shiftAmt = '0; carryIn = 1'b0;

    // Directed table
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].t, VECS[i].n, VECS[i].ci, VECS[i].op, VECS[i].res, VECS[i].co,
            reqName(VECS[i].t, VECS[i].n));
    end

    // Sweep every type at every amount with both carries (R1 R2 R3 R4 R5 R6 R7)
    ops[0] = 32'h80000001;
    ops[1] = $urandom(7);
    ops[2] = $urandom;
    ops[3] = $urandom | 32'h80000000;
    for (int t = 0; t < 8; t++) begin
      for (int n = 0; n < 32; n++) begin
        for (int k = 0; k < 4; k++) begin
          for (int c = 0; c < 2; c++) begin
            exp = refModel(3'(t), ops[k], n, c[0]);
            apply(3'(t), 5'(n), c[0], ops[k], exp[31:0], exp[32],
                  reqName(3'(t), 5'(n)));
          end
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule